// File: doc/BRIEF.md
# Sensor Register Access Sequencer

This block turns single-word host requests into the command-word streams that an I2C master core consumes. It accesses 16-bit registers in one slave device whose 7-bit bus address is a fixed parameter. After reset it first loads the master's clock timing settings and then enables the master. Only after that does it accept host traffic.

A host write of a register becomes a short burst: an addressed START, the register pointer, then the data bytes with the low byte first. A STOP is attached to the final byte. A host read becomes a pointer write that ends with STOP, then a fresh START in read direction, then one receive slot per byte. Only the final receive slot carries STOP. The received bytes are taken from the master's receive queue in arrival order and packed into the host word, with the first byte at the bottom. If the master reports a missing acknowledge, the sequencer drops the rest of the sequence and returns an error response.

The host side follows a wait-request convention. The host holds its request until `host_wait` falls. The response is valid in that one cycle.

Top module: `sensreg_seq`

## Requirements
- R1: After reset release, `cfg_we` pulses in four consecutive cycles. The writes go to index 0 (SCL low time), 1 (SCL high time), 2 (SDA hold time) and 3 (enable, value 1), in that order. `host_wait` stays high throughout, and no command word is pushed before all four writes are done.
- R2: Each command word is 10 bits. Bit 9 requests a START, bit 8 requests a STOP, and bits 7:0 carry the payload. An address payload is the 7-bit device address in bits 7:1 with bit 0 set to 1 for read and 0 for write (address 5 gives 0x0A / 0x0B).
- R3: A host write of value V to pointer P pushes exactly these words: START+address-write, P, V[7:0], then STOP+V[15:8]. For example, V=0x1234 and P=0 give 0x20A, 0x000, 0x034, 0x112.
- R4: A host read of pointer P pushes exactly these words: START+address-write, STOP+P, START+address-read, 0x000, 0x100.
- R5: For a read, the first received byte appears in `host_rdata[7:0]` and the second in `host_rdata[15:8]`. The value is valid in the cycle `host_wait` is low.
- R6: Once a request is presented, `host_wait` stays high until the sequence has finished. It is then low for exactly one cycle, and a write finishes in the cycle after its last push.
- R7: `cmd_push` is never high while `cmd_full` is high. After a stall the sequence resumes with no word lost or repeated.
- R8: `rx_pop` is never high while `rx_empty` is high. A read waits, with `host_wait` high, until both bytes have arrived.
- R9: A `nack_det` pulse during a transaction stops all further pushes and pops. The transaction ends with `host_err`=1 and `host_rdata`=0.
- R10: A `nack_det` pulse while no transaction is running has no effect: the next transaction completes with `host_err`=0.
- R11: Only one transaction runs at a time. If `host_wr` and `host_rd` are both asserted, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write request, held until `host_wait` is low |
| host_rd | input | 1 | Host read request, held until `host_wait` is low |
| host_ptr | input | 8 | Slave register pointer |
| host_wdata | input | 16 | Write value |
| host_wait | output | 1 | Low for one cycle when the request completes |
| host_rdata | output | 16 | Read value, valid while `host_wait` is low |
| host_err | output | 1 | Acknowledge failure, valid while `host_wait` is low |
| cfg_we | output | 1 | Timing-register write strobe to the master |
| cfg_idx | output | 2 | Timing-register index |
| cfg_wdata | output | 16 | Timing-register value |
| cmd_push | output | 1 | Push strobe into the master command queue |
| cmd_word | output | 10 | Command word (START, STOP, payload) |
| cmd_full | input | 1 | Master command queue full |
| rx_pop | output | 1 | Pop strobe for the master receive queue |
| rx_data | input | 8 | Head byte of the receive queue |
| rx_empty | input | 1 | Receive queue empty |
| nack_det | input | 1 | Missing-acknowledge pulse from the master |

## Verification
The hardest situation to reach is a missing acknowledge in the middle of a read, after some words are queued but before the address-read phase. The stimulus watches the count of pushed words and pulses `nack_det` on the exact cycle the third word would go out. It then confirms that no further words or pops appear. Backpressure is reached in a similar way: `cmd_full` is raised after the first pushed word of a write, and the bench counts pushes across the stall. Slow read data is produced by loading the receive queue model only many cycles after the read starts.

// File: rtl/sensreg_pkg.sv
`timescale 1ns/1ps
package sensreg_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_W     = BYTE_W + 2;
  localparam int NCFG      = 4;
  localparam int CFG_IDX_W = 2;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_CMD,
    ST_RX,
    ST_DONE
  } seq_state_e;

  // word layout: [9] start, [8] stop, [7:0] payload
  function automatic logic [CMD_W-1:0] mk_cmd(input logic sta, input logic sto,
                                              input logic [BYTE_W-1:0] pl);
    return {sta, sto, pl};
  endfunction
endpackage

// File: rtl/sensreg_init.sv
`timescale 1ns/1ps
module sensreg_init
  import sensreg_pkg::*;
#(
  parameter int CFG_W      = 16,
  parameter int T_SCL_LO   = 250,
  parameter int T_SCL_HI   = 250,
  parameter int T_SDA_HOLD = 60
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 cfg_we,
  output logic [CFG_IDX_W-1:0] cfg_idx,
  output logic [CFG_W-1:0]     cfg_wdata,
  output logic                 init_done
);
  logic [CFG_IDX_W-1:0] cnt_q;
  logic [CFG_W-1:0]     val;

  always_comb begin
    case (cnt_q)
      2'd0:    val = CFG_W'(T_SCL_LO);
      2'd1:    val = CFG_W'(T_SCL_HI);
      2'd2:    val = CFG_W'(T_SDA_HOLD);
      default: val = CFG_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      init_done <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_idx   <= '0;
      cfg_wdata <= '0;
    end else if (!init_done) begin
      cfg_we    <= 1'b1;
      cfg_idx   <= cnt_q;
      cfg_wdata <= val;
      if (cnt_q == CFG_IDX_W'(NCFG - 1)) init_done <= 1'b1;
      else                               cnt_q     <= cnt_q + 1'b1;
    end else begin
      cfg_we <= 1'b0;
    end
  end
endmodule

// File: rtl/sensreg_cmdgen.sv
`timescale 1ns/1ps
module sensreg_cmdgen
  import sensreg_pkg::*;
#(
  parameter int          NBYTES   = 2,
  parameter logic [6:0]  DEV_ADDR = 7'h05
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       active,
  input  logic                       abort,
  input  logic                       op_rd,
  input  logic [BYTE_W-1:0]          ptr,
  input  logic [BYTE_W*NBYTES-1:0]   wdata,
  input  logic                       cmd_full,
  output logic                       cmd_push,
  output logic [CMD_W-1:0]           cmd_word,
  output logic                       seq_last
);
  localparam int DATA_W = BYTE_W * NBYTES;
  localparam int N_WR   = 2 + NBYTES;
  localparam int N_RD   = 3 + NBYTES;
  localparam int STEP_W = $clog2(N_RD + 1);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;
  logic [STEP_W-1:0] k;
  logic [DATA_W-1:0] sh;

  always_comb begin
    last_step = op_rd ? STEP_W'(N_RD - 1) : STEP_W'(N_WR - 1);
    seq_last  = (step_q == last_step);
    k         = step_q - STEP_W'(2);
    sh        = wdata >> (BYTE_W * k);
    if (step_q == '0)
      cmd_word = mk_cmd(1'b1, 1'b0, {DEV_ADDR, 1'b0});
    else if (step_q == STEP_W'(1))
      cmd_word = mk_cmd(1'b0, op_rd, ptr);
    else if (op_rd && step_q == STEP_W'(2))
      cmd_word = mk_cmd(1'b1, 1'b0, {DEV_ADDR, 1'b1});
    else if (op_rd)
      cmd_word = mk_cmd(1'b0, seq_last, '0);
    else
      cmd_word = mk_cmd(1'b0, seq_last, sh[BYTE_W-1:0]);
    cmd_push = active && !cmd_full && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)               step_q <= '0;
    else if (cmd_push && !seq_last) step_q <= step_q + 1'b1;
  end
endmodule

// File: rtl/sensreg_rxasm.sv
`timescale 1ns/1ps
module sensreg_rxasm
  import sensreg_pkg::*;
#(
  parameter int NBYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      enable,
  input  logic                      rx_empty,
  input  logic [BYTE_W-1:0]         rx_data,
  output logic                      rx_pop,
  output logic                      rx_last,
  output logic [BYTE_W*NBYTES-1:0]  asm_nxt
);
  localparam int DATA_W = BYTE_W * NBYTES;
  localparam int CNT_W  = $clog2(NBYTES) + 1;

  logic [DATA_W-1:0] asm_q;
  logic [CNT_W-1:0]  cnt_q;

  generate
    if (NBYTES == 1) begin : g_single
      assign asm_nxt = rx_data;
    end else begin : g_multi
      assign asm_nxt = {rx_data, asm_q[DATA_W-1:BYTE_W]};
    end
  endgenerate

  assign rx_pop  = enable && !rx_empty;
  assign rx_last = rx_pop && (cnt_q == CNT_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      asm_q <= '0;
      cnt_q <= '0;
    end else if (rx_pop) begin
      asm_q <= asm_nxt;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sensreg_seq.sv
`timescale 1ns/1ps
module sensreg_seq
  import sensreg_pkg::*;
#(
  parameter int         NBYTES     = 2,
  parameter logic [6:0] DEV_ADDR   = 7'h05,
  parameter int         CFG_W      = 16,
  parameter int         T_SCL_LO   = 250,
  parameter int         T_SCL_HI   = 250,
  parameter int         T_SDA_HOLD = 60
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [7:0]               host_ptr,
  input  logic [8*NBYTES-1:0]      host_wdata,
  output logic                     host_wait,
  output logic [8*NBYTES-1:0]      host_rdata,
  output logic                     host_err,
  output logic                     cfg_we,
  output logic [1:0]               cfg_idx,
  output logic [CFG_W-1:0]         cfg_wdata,
  output logic                     cmd_push,
  output logic [9:0]               cmd_word,
  input  logic                     cmd_full,
  output logic                     rx_pop,
  input  logic [7:0]               rx_data,
  input  logic                     rx_empty,
  input  logic                     nack_det
);
  localparam int DATA_W = BYTE_W * NBYTES;

  seq_state_e        state_q;
  logic              op_rd_q;
  logic [7:0]        ptr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              init_done;
  logic              accept;
  logic              seq_last;
  logic              rx_last;
  logic [DATA_W-1:0] asm_nxt;

  sensreg_init #(
    .CFG_W(CFG_W), .T_SCL_LO(T_SCL_LO), .T_SCL_HI(T_SCL_HI), .T_SDA_HOLD(T_SDA_HOLD)
  ) u_init (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .init_done(init_done)
  );

  sensreg_cmdgen #(.NBYTES(NBYTES), .DEV_ADDR(DEV_ADDR)) u_cmd (
    .clk(clk), .rst(rst), .clear(accept), .active(state_q == ST_CMD),
    .abort(nack_det), .op_rd(op_rd_q), .ptr(ptr_q), .wdata(wdata_q),
    .cmd_full(cmd_full), .cmd_push(cmd_push), .cmd_word(cmd_word), .seq_last(seq_last)
  );

  sensreg_rxasm #(.NBYTES(NBYTES)) u_rx (
    .clk(clk), .rst(rst), .clear(accept), .enable(state_q == ST_RX && !nack_det),
    .rx_empty(rx_empty), .rx_data(rx_data), .rx_pop(rx_pop), .rx_last(rx_last),
    .asm_nxt(asm_nxt)
  );

  assign accept     = (state_q == ST_IDLE) && (host_wr || host_rd);
  assign host_wait  = (state_q != ST_DONE);
  assign host_rdata = rdata_q;
  assign host_err   = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      op_rd_q <= 1'b0;
      ptr_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_INIT: if (init_done) state_q <= ST_IDLE;
        ST_IDLE: if (accept) begin
          op_rd_q <= !host_wr;
          ptr_q   <= host_ptr;
          wdata_q <= host_wdata;
          state_q <= ST_CMD;
        end
        ST_CMD: if (nack_det) begin
          err_q   <= 1'b1;
          rdata_q <= '0;
          state_q <= ST_DONE;
        end else if (cmd_push && seq_last) begin
          if (op_rd_q) state_q <= ST_RX;
          else begin
            err_q   <= 1'b0;
            rdata_q <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_RX: if (nack_det) begin
          err_q   <= 1'b1;
          rdata_q <= '0;
          state_q <= ST_DONE;
        end else if (rx_last) begin
          err_q   <= 1'b0;
          rdata_q <= asm_nxt;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/sensreg_seq_chk.sv
`timescale 1ns/1ps
module sensreg_seq_chk #(
  parameter int NBYTES = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                host_wait,
  input logic [8*NBYTES-1:0] host_rdata,
  input logic                host_err,
  input logic                cfg_we,
  input logic                cmd_push,
  input logic                cmd_full,
  input logic                rx_pop,
  input logic                rx_empty,
  input logic                nack_det
);
  logic [2:0] cfg_cnt;

  always_ff @(posedge clk) begin
    if (rst)                            cfg_cnt <= '0;
    else if (cfg_we && cfg_cnt != 3'd4) cfg_cnt <= cfg_cnt + 1'b1;
  end

  p_init_first_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_push |-> cfg_cnt == 3'd4);
  p_cfg_held_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> host_wait);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    !host_wait |=> host_wait);
  p_push_in_txn_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_push |-> host_wait);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_push |-> !cmd_full);
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> !rx_empty);
  p_nack_halts_r9: assert property (@(posedge clk) disable iff (rst)
    nack_det |-> !cmd_push && !rx_pop);
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!host_wait && host_err) |-> host_rdata == '0);
endmodule

bind sensreg_seq sensreg_seq_chk #(.NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst(rst), .host_wait(host_wait), .host_rdata(host_rdata),
  .host_err(host_err), .cfg_we(cfg_we), .cmd_push(cmd_push), .cmd_full(cmd_full),
  .rx_pop(rx_pop), .rx_empty(rx_empty), .nack_det(nack_det)
);

// File: tb/sensreg_seq_tb_top.sv
`timescale 1ns/1ps
module sensreg_seq_tb_top;
  localparam int TLO = 250, THI = 250, THOLD = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_ptr = 0;
  logic [15:0] host_wdata = 0;
  logic        host_wait, host_err;
  logic [15:0] host_rdata;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic        cmd_push;
  logic [9:0]  cmd_word;
  logic        cmd_full = 0;
  logic        rx_pop;
  logic [7:0]  rx_data;
  logic        rx_empty;
  logic        nack_det = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sensreg_seq #(.NBYTES(2), .DEV_ADDR(7'h05), .CFG_W(16),
    .T_SCL_LO(TLO), .T_SCL_HI(THI), .T_SDA_HOLD(THOLD)) dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_ptr(host_ptr),
    .host_wdata(host_wdata), .host_wait(host_wait), .host_rdata(host_rdata),
    .host_err(host_err), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cmd_push(cmd_push), .cmd_word(cmd_word), .cmd_full(cmd_full), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_empty(rx_empty), .nack_det(nack_det));

  // master-side models
  logic [9:0]  cmd_log [0:255];
  int          cmd_n = 0;
  logic [1:0]  cfg_ilog [0:15];
  logic [15:0] cfg_dlog [0:15];
  int          cfg_stamp [0:15];
  int          cfg_n = 0;
  logic [7:0]  rxq [0:15];
  int          rx_wr = 0, rx_rd = 0;

  always @(posedge clk) begin
    if (cmd_push) begin
      cmd_log[cmd_n[7:0]] <= cmd_word;
      cmd_n <= cmd_n + 1;
    end
    if (cfg_we && cfg_n < 16) begin
      cfg_ilog[cfg_n[3:0]]  <= cfg_idx;
      cfg_dlog[cfg_n[3:0]]  <= cfg_wdata;
      cfg_stamp[cfg_n[3:0]] <= cyc;
      cfg_n <= cfg_n + 1;
    end
    if (rx_pop) rx_rd <= rx_rd + 1;
  end
  assign rx_empty = (rx_wr == rx_rd);
  assign rx_data  = rxq[rx_rd[3:0]];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push_rx(input logic [7:0] b);
    rxq[rx_wr[3:0]] = b;
    rx_wr++;
  endtask

  task automatic run_txn(input bit wr, input bit rd, input logic [7:0] ptr,
                         input logic [15:0] wd, output logic [15:0] rdo,
                         output logic erro, output int nwait);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_ptr = ptr; host_wdata = wd; nwait = 0;
    while (host_wait === 1'b1) begin
      @(negedge clk);
      nwait++;
    end
    rdo = host_rdata; erro = host_err;
    host_wr = 0; host_rd = 0;
    @(negedge clk);
    check("R6 done lasts one cycle", {31'd0, host_wait}, 1);
  endtask

  function automatic logic [9:0] wr_word(input int i, input logic [7:0] p, input logic [15:0] v);
    case (i)
      0: return 10'h20A;
      1: return {2'b00, p};
      2: return {2'b00, v[7:0]};
      default: return {2'b01, v[15:8]};
    endcase
  endfunction

  function automatic logic [9:0] rd_word(input int i, input logic [7:0] p);
    case (i)
      0: return 10'h20A;
      1: return {2'b01, p};
      2: return 10'h20B;
      3: return 10'h000;
      default: return 10'h100;
    endcase
  endfunction

  task automatic t_reset();
    bit all_high = 1;
    repeat (3) @(negedge clk);
    check("R1 reset wait", {31'd0, host_wait}, 1);
    check("R1 reset push", {31'd0, cmd_push}, 0);
    check("R1 reset cfg", {31'd0, cfg_we}, 0);
    rst = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (host_wait !== 1'b1) all_high = 0;
    end
    check("R1 wait high in init", {31'd0, all_high}, 1);
    check("R1 cfg count", cfg_n, 4);
    check("R1 cfg idx0", cfg_ilog[0], 0);
    check("R1 cfg idx1", cfg_ilog[1], 1);
    check("R1 cfg idx2", cfg_ilog[2], 2);
    check("R1 cfg idx3", cfg_ilog[3], 3);
    check("R1 scl low", cfg_dlog[0], TLO);
    check("R1 scl high", cfg_dlog[1], THI);
    check("R1 sda hold", cfg_dlog[2], THOLD);
    check("R1 enable", cfg_dlog[3], 1);
    check("R1 consecutive", cfg_stamp[3] - cfg_stamp[0], 3);
    check("R1 no push in init", cmd_n, 0);
  endtask

  task automatic t_write(input logic [7:0] p, input logic [15:0] v, input bit both);
    int base = cmd_n; logic [15:0] r; logic e; int nw;
    run_txn(1, both, p, v, r, e, nw);
    check(both ? "R11 write wins count" : "R3 write count", cmd_n - base, 4);
    for (int i = 0; i < 4; i++)
      check(both ? "R11 write word" : "R3 write word", cmd_log[(base + i) % 256], wr_word(i, p, v));
    check("R2 write address byte", cmd_log[base % 256], 10'h20A);
    check("R6 write err", {31'd0, e}, 0);
  endtask

  task automatic t_read(input logic [7:0] p, input logic [15:0] v, input int dly);
    int base = cmd_n; logic [15:0] r; logic e; int nw;
    if (dly == 0) begin
      push_rx(v[7:0]); push_rx(v[15:8]);
      run_txn(0, 1, p, 0, r, e, nw);
    end else begin
      fork
        run_txn(0, 1, p, 0, r, e, nw);
        begin
          repeat (dly) @(negedge clk);
          push_rx(v[7:0]); push_rx(v[15:8]);
        end
      join
      check("R8 waited for data", {31'd0, nw > dly}, 1);
    end
    check("R4 read count", cmd_n - base, 5);
    for (int i = 0; i < 5; i++)
      check("R4 read word", cmd_log[(base + i) % 256], rd_word(i, p));
    check("R2 read address byte", cmd_log[(base + 2) % 256], 10'h20B);
    check("R5 read data", r, v);
    check("R5 read err", {31'd0, e}, 0);
    check("R8 rx drained", rx_wr - rx_rd, 0);
  endtask

  task automatic t_stall(input logic [7:0] p, input logic [15:0] v);
    int base = cmd_n; int snap = 0; logic [15:0] r; logic e; int nw;
    fork
      run_txn(1, 0, p, v, r, e, nw);
      begin
        do @(negedge clk); while (cmd_n != base + 1);
        cmd_full = 1;
        snap = cmd_n;
        repeat (6) @(negedge clk);
        check("R7 no push while full", cmd_n, snap);
        cmd_full = 0;
      end
    join
    check("R7 stall count", cmd_n - base, 4);
    for (int i = 0; i < 4; i++)
      check("R7 stall word", cmd_log[(base + i) % 256], wr_word(i, p, v));
  endtask

  task automatic t_nack_mid(input logic [7:0] p);
    int base = cmd_n; int rd0 = rx_rd; logic [15:0] r; logic e; int nw;
    fork
      run_txn(0, 1, p, 0, r, e, nw);
      begin
        do @(negedge clk); while (cmd_n != base + 2);
        nack_det = 1;
        @(negedge clk);
        nack_det = 0;
      end
    join
    check("R9 err flagged", {31'd0, e}, 1);
    check("R9 rdata zero", r, 0);
    check("R9 pushes stopped", cmd_n - base, 2);
    repeat (5) @(negedge clk);
    check("R9 no later push", cmd_n - base, 2);
    check("R9 no pop", rx_rd - rd0, 0);
  endtask

  task automatic t_nack_idle();
    @(negedge clk); nack_det = 1;
    @(negedge clk); nack_det = 0;
    repeat (2) @(negedge clk);
    check("R10 idle wait", {31'd0, host_wait}, 1);
    t_write(8'h07, 16'h5AA5, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_write(8'h00, 16'h1234, 0);
    t_read(8'h00, 16'h1234, 0);
    t_read(8'h03, 16'hBEEF, 0);
    t_read(8'h01, 16'h00FF, 25);
    t_stall(8'h02, 16'hC3A1);
    t_nack_mid(8'h04);
    t_nack_idle();
    t_write(8'h09, 16'h8001, 1);
    t_read(8'h09, 16'hA55A, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule